// File: doc/BRIEF.md
# Potentiometer Register Bank Controller

This block is the register file behind a four-channel digital potentiometer. It keeps a live 7-bit wiper setting for each channel and a stored start-up setting for each channel. It also holds three general-purpose stored bytes and one access control byte. A serial front end hands it single-cycle read and write requests on a flat address space of nine locations. A separate sequencer commits stored values and reports its busy state back to this block.

Bit 7 of the control byte chooses where addresses 0 to 3 go. When the bit is 0 they reach the stored setting, and a write there also updates the live wiper. When the bit is 1 they reach only the live wiper. Each write that lands in stored space sends a one-cycle request, with address and data, to the sequencer. While the sequencer is busy, every write is refused. Shutdown is driven per channel from an active-low pin and a control bit. It never alters a wiper value, so each channel returns to its old tap when shutdown ends.

Top module: `potbank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every live wiper and stored setting is 40h, the general-purpose bytes are 00h, the volatile-select bit is 0, the shutdown-control bit is 1, rd_data is 00h and nv_wr_req is 0.
- R2: With volatile-select 0, a write to address 0 to 3 (channel = address) sets both the stored setting and the live wiper of that channel, and a read there returns the stored setting.
- R3: With volatile-select 1, a write to address 0 to 3 sets only the live wiper, leaves the stored setting unchanged, raises no sequencer request, and a read returns the live wiper.
- R4: Addresses 4, 5 and 6 are general-purpose bytes that keep and return all 8 bits written.
- R5: Address 8 is the control byte: bit 7 volatile-select, bit 6 shutdown-control (1 = run), bit 5 the live busy input (read-only), bits 4..0 read 0. Writes to bits 5..0 have no effect.
- R6: While nv_busy is 1, every write request is refused and changes no register.
- R7: chan_off[i] is 1 exactly when shdn_pin_n is 0 or the shutdown-control bit is 0, for every channel.
- R8: During shutdown, all registers stay readable and writable, and the wiper outputs keep their values, so after shutdown ends each wiper sits where it did before.
- R9: Wiper and stored settings are 7 bits (00h = tap nearest the low terminal, 7Fh = nearest the high terminal). Bit 7 of written data is dropped at addresses 0 to 3, and those reads return bit 7 as 0.
- R10: Address 7 and addresses 9 to 15 read 00h, and writes to them change nothing and raise no request.
- R11: An accepted write to a stored setting (R2) or a general-purpose byte raises nv_wr_req for exactly the next cycle, with nv_wr_addr and nv_wr_data set to the address and the stored value.
- R12: A read request updates rd_data at the next clock edge. rd_data holds its value on cycles without a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the read request |
| nv_busy | input | 1 | Stored-value sequencer busy |
| shdn_pin_n | input | 1 | Active-low shutdown pin |
| nv_wr_req | output | 1 | One-cycle commit request to the sequencer |
| nv_wr_addr | output | 4 | Address of the commit |
| nv_wr_data | output | 8 | Value to commit |
| wiper_pos | output | 28 | Live wiper settings, channel i at bits [7i+6:7i] |
| chan_off | output | 4 | Per-channel shutdown, active high |

## Verification
Directed sequences first write each region under both settings of the volatile-select bit. They then read the same addresses back, which separates stored-setting updates from live-only updates and shows whether a request was issued. Writes with bit 7 set and accesses to unmapped addresses show whether masking and decode are correct. Busy-phase writes to every region show whether the refusal covers all of them. Pin and control-bit shutdown are toggled around writes to prove that the wiper values survive. A seeded random mix of reads and writes, with random busy and pin levels, is then compared against a bench model of the map.

// File: rtl/potbank_pkg.sv
// Shared definitions for the potentiometer register bank.
// Assumes the control byte is 8 bits wide with fixed flag positions.
package potbank_pkg;
    typedef enum logic [2:0] {
        RGN_CHAN,
        RGN_GP,
        RGN_RSV,
        RGN_ACR,
        RGN_NONE
    } region_t;

    localparam int ACR_VOL_BIT = 7;
    localparam int ACR_SHD_BIT = 6;
    localparam int ACR_BSY_BIT = 5;
endpackage

// File: rtl/potbank_decode.sv
// Address decoder: sorts a request into a region and produces the
// write strobes. Every strobe is suppressed while the sequencer is busy.
// Assumes a channel block, then a general-purpose block, then one
// reserved slot, then the control byte.
module potbank_decode
    import potbank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int NUM_GP = 3,
    parameter int ADDR_W = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              vol_sel,
    input  logic              nv_busy,
    output region_t           region,
    output logic [NUM_CH-1:0] ivr_we,
    output logic [NUM_CH-1:0] wip_we,
    output logic [NUM_GP-1:0] gp_we,
    output logic              acr_we,
    output logic              nv_start
);
    localparam int RSV_ADDR = NUM_CH + NUM_GP;
    localparam int ACR_ADDR = RSV_ADDR + 1;

    logic wr_ok;

    // Classify the address into a region.
    always_comb begin
        if (int'(req_addr) < NUM_CH)                 region = RGN_CHAN;
        else if (int'(req_addr) < NUM_CH + NUM_GP)   region = RGN_GP;
        else if (int'(req_addr) == RSV_ADDR)         region = RGN_RSV;
        else if (int'(req_addr) == ACR_ADDR)         region = RGN_ACR;
        else                                         region = RGN_NONE;
    end

    assign wr_ok  = req_valid && req_write && !nv_busy;
    assign acr_we = wr_ok && (region == RGN_ACR);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_we
        assign ivr_we[i] = wr_ok && !vol_sel && (req_addr == ADDR_W'(i));
        assign wip_we[i] = wr_ok &&  vol_sel && (req_addr == ADDR_W'(i));
    end

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_we
        assign gp_we[g] = wr_ok && (req_addr == ADDR_W'(NUM_CH + g));
    end

    assign nv_start = (|ivr_we) || (|gp_we);
endmodule

// File: rtl/potbank_chan.sv
// One potentiometer channel: the live wiper and its stored start-up
// setting. A stored-setting write also loads the live wiper.
// Assumes the strobes are mutually exclusive.
module potbank_chan #(
    parameter int               WIPER_W = 7,
    parameter logic [WIPER_W-1:0] INIT  = 7'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ivr_we,
    input  logic               wip_we,
    input  logic [WIPER_W-1:0] wdata,
    output logic [WIPER_W-1:0] wiper,
    output logic [WIPER_W-1:0] ivr
);
    // Hold the live and stored settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper <= INIT;
            ivr   <= INIT;
        end else if (ivr_we) begin
            wiper <= wdata;
            ivr   <= wdata;
        end else if (wip_we) begin
            wiper <= wdata;
        end
    end

    // R2: a stored write leaves live and stored copies equal
    a_r2_copy_to_wiper: assert property (@(posedge clk) disable iff (!rst_n)
        ivr_we |=> (wiper == ivr));
    // R3: a live-only write keeps the stored setting
    a_r3_stored_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wip_we && !ivr_we) |=> $stable(ivr));
endmodule

// File: rtl/potbank_acr.sv
// Access control byte: volatile-select and shutdown-control flags plus
// the live busy flag on read. Assumes an 8-bit control byte.
module potbank_acr
    import potbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              vol_in,
    input  logic              shd_in,
    input  logic              nv_busy,
    output logic              vol_sel,
    output logic              shd_bit,
    output logic [DATA_W-1:0] rd_val
);
    // Store the two writable flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_sel <= 1'b0;
            shd_bit <= 1'b1;
        end else if (we) begin
            vol_sel <= vol_in;
            shd_bit <= shd_in;
        end
    end

    // Assemble the read view with the unused bits at zero.
    always_comb begin
        rd_val              = '0;
        rd_val[ACR_VOL_BIT] = vol_sel;
        rd_val[ACR_SHD_BIT] = shd_bit;
        rd_val[ACR_BSY_BIT] = nv_busy;
    end

    // R5: an accepted write lands in both flags
    a_r5_flags_taken: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (vol_sel == $past(vol_in)) && (shd_bit == $past(shd_in)));
endmodule

// File: rtl/potbank_ctrl.sv
// Potentiometer register bank controller (top). Serves single-cycle
// reads and writes and produces live wiper settings, shutdown outputs
// and commit requests. Assumes the sequencer raises nv_busy once it
// accepts a commit, and that requests arrive one per cycle.
module potbank_ctrl
    import potbank_pkg::*;
#(
    parameter int                 NUM_CH     = 4,
    parameter int                 NUM_GP     = 3,
    parameter int                 WIPER_W    = 7,
    parameter int                 DATA_W     = 8,
    parameter int                 ADDR_W     = 4,
    parameter logic [WIPER_W-1:0] WIPER_INIT = 7'h40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      nv_busy,
    input  logic                      shdn_pin_n,
    output logic                      nv_wr_req,
    output logic [ADDR_W-1:0]         nv_wr_addr,
    output logic [DATA_W-1:0]         nv_wr_data,
    output logic [NUM_CH*WIPER_W-1:0] wiper_pos,
    output logic [NUM_CH-1:0]         chan_off
);
    localparam int RSV_ADDR = NUM_CH + NUM_GP;

    region_t             region;
    logic [NUM_CH-1:0]   ivr_we, wip_we;
    logic [NUM_GP-1:0]   gp_we;
    logic                acr_we, nv_start;
    logic                vol_sel, shd_bit;
    logic [DATA_W-1:0]   acr_rd, rd_next, nv_next;
    logic [WIPER_W-1:0]  wip_arr [NUM_CH];
    logic [WIPER_W-1:0]  ivr_arr [NUM_CH];
    logic [DATA_W-1:0]   gp_q    [NUM_GP];
    logic                rd_req;

    assign rd_req = req_valid && !req_write;

    potbank_decode #(.NUM_CH(NUM_CH), .NUM_GP(NUM_GP), .ADDR_W(ADDR_W)) i_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .vol_sel   (vol_sel),
        .nv_busy   (nv_busy),
        .region    (region),
        .ivr_we    (ivr_we),
        .wip_we    (wip_we),
        .gp_we     (gp_we),
        .acr_we    (acr_we),
        .nv_start  (nv_start)
    );

    potbank_acr #(.DATA_W(DATA_W)) i_acr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (acr_we),
        .vol_in  (req_wdata[ACR_VOL_BIT]),
        .shd_in  (req_wdata[ACR_SHD_BIT]),
        .nv_busy (nv_busy),
        .vol_sel (vol_sel),
        .shd_bit (shd_bit),
        .rd_val  (acr_rd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        potbank_chan #(.WIPER_W(WIPER_W), .INIT(WIPER_INIT)) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ivr_we (ivr_we[i]),
            .wip_we (wip_we[i]),
            .wdata  (req_wdata[WIPER_W-1:0]),
            .wiper  (wip_arr[i]),
            .ivr    (ivr_arr[i])
        );
        assign wiper_pos[i*WIPER_W +: WIPER_W] = wip_arr[i];
        assign chan_off[i] = ~(shdn_pin_n & shd_bit);
    end

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        // Hold one general-purpose byte.
        always_ff @(posedge clk) begin
            if (!rst_n)        gp_q[g] <= '0;
            else if (gp_we[g]) gp_q[g] <= req_wdata;
        end
    end

    // Select the read value for the addressed location.
    always_comb begin
        rd_next = '0;
        case (region)
            RGN_CHAN: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (req_addr == ADDR_W'(i))
                        rd_next = DATA_W'(vol_sel ? wip_arr[i] : ivr_arr[i]);
                end
            end
            RGN_GP: begin
                for (int g = 0; g < NUM_GP; g++) begin
                    if (req_addr == ADDR_W'(NUM_CH + g)) rd_next = gp_q[g];
                end
            end
            RGN_ACR: rd_next = acr_rd;
            default: rd_next = '0;
        endcase
    end

    // Commit data: channel values lose bit 7, bytes pass whole.
    assign nv_next = (region == RGN_CHAN) ? DATA_W'(req_wdata[WIPER_W-1:0]) : req_wdata;

    // Register read data on read requests only.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_next;
    end

    // Issue the one-cycle commit request to the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_wr_req  <= 1'b0;
            nv_wr_addr <= '0;
            nv_wr_data <= '0;
        end else begin
            nv_wr_req <= nv_start;
            if (nv_start) begin
                nv_wr_addr <= req_addr;
                nv_wr_data <= nv_next;
            end
        end
    end

    // R6: a write while busy leaves every wiper unchanged
    a_r6_busy_freezes_wipers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && nv_busy) |=> $stable(wiper_pos));
    // R7: the pin alone forces every channel off
    a_r7_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_pin_n |-> (&chan_off));
    // R7: the control bit alone forces every channel off
    a_r7_bit_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !shd_bit |-> (&chan_off));
    // R9: channel reads return bit 7 as zero
    a_r9_wiper_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && region == RGN_CHAN) |=> (rd_data[DATA_W-1:WIPER_W] == '0));
    // R10: the reserved slot reads zero
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && int'(req_addr) == RSV_ADDR) |=> (rd_data == '0));
    // R11: a request only follows an accepted write
    a_r11_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_req |-> $past(req_valid && req_write && !nv_busy));
    // R12: rd_data holds without a read request
    a_r12_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));
endmodule

// File: tb/test_potbank_ctrl.sv
module test_potbank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        nv_busy = 1'b0, shdn_pin_n = 1'b1;
    logic        nv_wr_req;
    logic [3:0]  nv_wr_addr;
    logic [7:0]  nv_wr_data;
    logic [27:0] wiper_pos;
    logic [3:0]  chan_off;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [6:0] m_wip [4];
    logic [6:0] m_ivr [4];
    logic [7:0] m_gp  [3];
    logic       m_vol, m_shb;

    always #2 clk = ~clk;

    potbank_ctrl i_potbank_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .nv_busy(nv_busy), .shdn_pin_n(shdn_pin_n), .nv_wr_req(nv_wr_req),
        .nv_wr_addr(nv_wr_addr), .nv_wr_data(nv_wr_data),
        .wiper_pos(wiper_pos), .chan_off(chan_off)
    );

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        if (a < 4)       return {1'b0, (m_vol ? m_wip[a] : m_ivr[a])};
        else if (a < 7)  return m_gp[a-4];
        else if (a == 8) return {m_vol, m_shb, nv_busy, 5'b0};
        else             return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        for (int i = 0; i < 4; i++)
            check({tag, " R8 wiper"}, 32'(wiper_pos[i*7 +: 7]), 32'(m_wip[i]));
        check({tag, " R7 chan_off"}, 32'(chan_off), 32'({4{~(shdn_pin_n & m_shb)}}));
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input string tag);
        logic       exp_nv;
        logic [7:0] exp_d;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        exp_nv = !nv_busy && ((a < 4 && !m_vol) || (a >= 4 && a < 7));
        exp_d  = (a < 4) ? {1'b0, d[6:0]} : d;
        if (!nv_busy) begin
            if (a < 4) begin
                m_wip[a] = d[6:0];
                if (!m_vol) m_ivr[a] = d[6:0];
            end else if (a < 7) m_gp[a-4] = d;
            else if (a == 8) begin m_vol = d[7]; m_shb = d[6]; end
        end
        @(negedge clk);
        req_valid = 0;
        check({tag, " R11 req"}, 32'(nv_wr_req), 32'(exp_nv));
        if (exp_nv) begin
            check({tag, " R11 addr"}, 32'(nv_wr_addr), 32'(a));
            check({tag, " R11 data"}, 32'(nv_wr_data), 32'(exp_d));
        end
    endtask

    task automatic do_read(input logic [3:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        e = exp_rd(a);
        @(negedge clk);
        req_valid = 0;
        check({tag, " R12 rd"}, 32'(rd_data), 32'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin m_wip[i] = 7'h40; m_ivr[i] = 7'h40; end
        for (int g = 0; g < 3; g++) m_gp[g] = 8'h00;
        m_vol = 0; m_shb = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_outs("R1");
        check("R1 rd_data", 32'(rd_data), 32'h0);
        check("R1 nv_wr_req", 32'(nv_wr_req), 32'h0);
        do_read(4'd8, "R1 acr");
        do_read(4'd0, "R1 ivr0");
        do_read(4'd5, "R1 gp");
        // R2 stored write reaches the wiper
        do_write(4'd1, 8'h25, "R2");
        check_outs("R2");
        do_read(4'd1, "R2");
        // R9 bit 7 dropped
        do_write(4'd2, 8'hFF, "R9");
        do_read(4'd2, "R9");
        // R5 control byte, low bits ignored, also shutdown by bit (R7)
        do_write(4'd8, 8'hBF, "R5");
        do_read(4'd8, "R5");
        check_outs("R7 bit");
        do_write(4'd8, 8'hC0, "R5");
        // R3 live-only write
        do_write(4'd1, 8'h11, "R3");
        do_read(4'd1, "R3 live");
        do_write(4'd8, 8'h40, "R3");
        do_read(4'd1, "R3 stored");
        check_outs("R3");
        // R4 general-purpose bytes
        do_write(4'd4, 8'hA5, "R4");
        do_write(4'd5, 8'h3C, "R4");
        do_write(4'd6, 8'hFE, "R4");
        do_read(4'd4, "R4"); do_read(4'd5, "R4"); do_read(4'd6, "R4");
        // R10 reserved and unmapped
        do_write(4'd7, 8'h99, "R10");
        do_write(4'd12, 8'h77, "R10");
        do_read(4'd7, "R10"); do_read(4'd12, "R10");
        check_outs("R10");
        // R6 busy refuses all writes
        @(negedge clk); nv_busy = 1;
        do_write(4'd0, 8'h05, "R6");
        do_write(4'd8, 8'h80, "R6");
        do_write(4'd6, 8'h01, "R6");
        check_outs("R6");
        do_read(4'd8, "R6 busy flag");
        do_read(4'd6, "R6 gp");
        @(negedge clk); nv_busy = 0;
        do_read(4'd0, "R6 ivr");
        // R7/R8 pin shutdown, access kept, wipers kept
        @(negedge clk); shdn_pin_n = 0;
        @(negedge clk); check_outs("R7 pin");
        do_write(4'd3, 8'h7A, "R8");
        do_read(4'd3, "R8");
        check_outs("R8 shut");
        @(negedge clk); shdn_pin_n = 1;
        @(negedge clk); check_outs("R8 resume");
        // R12 hold without read
        do_read(4'd4, "R12");
        hold = rd_data;
        repeat (3) @(negedge clk);
        check("R12 hold", 32'(rd_data), 32'(hold));
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [3:0] a;
            logic [7:0] d;
            @(negedge clk);
            nv_busy    = ($urandom % 8) == 0;
            shdn_pin_n = ($urandom % 6) != 0;
            a = (($urandom % 4) == 0) ? 4'($urandom) : 4'($urandom % 9);
            d = 8'($urandom);
            if (a == 8 && ($urandom % 2)) d[6] = 1'b1;
            if ($urandom % 2) do_write(a, d, "RND R2");
            else              do_read(a, "RND R2");
            check_outs("RND");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule